// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Processor Core

This block is a compact processor core. It has a 16-bit datapath, a 16-bit program counter and sixteen general registers. It runs sixteen instructions that cover register arithmetic and logic, arithmetic and logic with a short constant, word load and store, equal and not-equal branches, single-position shifts, a linked jump and a jump through a register. Every instruction is one 16-bit word. A flat 4-bit opcode in bits [15:12] selects the operation directly. The remaining twelve bits hold three 4-bit fields, or one 12-bit jump target.

The core shares one memory port between instruction fetch and data access. It drives an address, write data and a one-cycle write strobe, and it expects read data one cycle after it presents an address. Each instruction passes through a short state sequence whose length depends on its class. A jump finishes in three cycles and a branch in four. An arithmetic, logic, shift or store instruction takes five cycles, and a load takes six. After reset the core starts fetching at address zero and then runs on its own.

Top module: `mc16_core`

## Requirements
- R1: While reset is held, and in the first fetch after it, the core presents address 0 with the write strobe low.
- R2: Opcode [15:12] values: 0 ADD, 1 SUB, 2 AND, 3 OR, 4 SLT, 5 ADDI, 6 ANDI, 7 ORI, 8 SLTI, 9 LW, 10 SW, 11 BEQ, 12 BNE, 13 SHIFT, 14 JAL, 15 JR. Field [11:8] is the destination or second register, [7:4] is the first register, and [3:0] is a third register, constant, offset or shift kind.
- R3: ADD, SUB, AND, OR and SLT write reg[7:4] op reg[3:0] into reg[11:8]. SLT compares signed values and yields 1 or 0.
- R4: ADDI and SLTI sign-extend the 4-bit constant. ANDI and ORI zero-extend it. The result goes to reg[11:8].
- R5: LW reads memory at reg[7:4] + sign-extended [3:0] into reg[11:8]. SW writes reg[11:8] to that address.
- R6: BEQ and BNE compare reg[7:4] with reg[11:8] by subtraction. When the condition holds, the PC becomes (address of the branch + 1) + sign-extended [3:0]. Otherwise execution falls through.
- R7: SHIFT moves reg[7:4] by one position into reg[11:8]. Kind [3:0]: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate left, 4 rotate right. Any other kind copies the value unchanged.
- R8: JAL writes its own address + 1 into r15 and jumps to {upper four PC bits, [11:0]}. JR jumps to the value of reg[3:0].
- R9: r0 always reads zero, and writes to it have no effect.
- R10: Cycles per instruction: JAL/JR 3, BEQ/BNE 4, ALU, immediate and SHIFT 5, SW 5 with its write in the last cycle, LW 6.
- R11: The write strobe rises only for SW and lasts exactly one cycle.
- R12: Each fetch presents the current PC as the memory address, and instructions execute in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 16 | Memory address for a fetch, load or store |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | One-cycle store strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |

## Verification
The bench runs a program whose only visible results are stores. It checks the address, the value and the cycle gap of every store against a list worked out by hand.

Several corner cases are targeted:
- Negative constants against zero-extended ANDI/ORI: a wrong extension flips the upper byte of the stored result.
- Signed SLT/SLTI with mixed signs: an unsigned compare stores the opposite bit.
- Every shift kind plus an undefined kind: a mixed-up kind or rotate gives a wrong pattern.
- Branches taken forward, taken backward in a counted loop, and not taken: a wrong branch base or offset extension runs a skipped store or loops the wrong number of times.
- JAL linking and a JR return: a wrong link value or target reorders or corrupts the stores.
- A write to r0 and a negative store offset: a core that lets r0 change stores a nonzero value, and one that zero-extends the offset stores to the wrong address.
- Gaps between stores: a core with the wrong cycle count for a class shows the wrong gap.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  localparam int unsigned INSTR_W = 16;
  localparam int unsigned OPC_W   = 4;
  localparam int unsigned RIDX_W  = 4;
  localparam int unsigned IMM_W   = 4;
  localparam int unsigned JADDR_W = 12;
  localparam int unsigned LINK_REG = 15;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_SLT   = 4'd4,
    OP_ADDI  = 4'd5,
    OP_ANDI  = 4'd6,
    OP_ORI   = 4'd7,
    OP_SLTI  = 4'd8,
    OP_LW    = 4'd9,
    OP_SW    = 4'd10,
    OP_BEQ   = 4'd11,
    OP_BNE   = 4'd12,
    OP_SHIFT = 4'd13,
    OP_JAL   = 4'd14,
    OP_JR    = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_REGRD  = 3'd2,
    ST_EXEC   = 3'd3,
    ST_MEM    = 3'd4,
    ST_WB     = 3'd5
  } state_e;

  typedef enum logic [2:0] {
    AL_ADD = 3'd0,
    AL_SUB = 3'd1,
    AL_AND = 3'd2,
    AL_OR  = 3'd3,
    AL_SLT = 3'd4,
    AL_SHF = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_MEM  = 2'd1,
    WB_LINK = 2'd2
  } wb_sel_e;

  localparam logic [3:0] SHK_LSL = 4'd0;
  localparam logic [3:0] SHK_LSR = 4'd1;
  localparam logic [3:0] SHK_ASR = 4'd2;
  localparam logic [3:0] SHK_ROL = 4'd3;
  localparam logic [3:0] SHK_ROR = 4'd4;

  typedef struct packed {
    logic    ir_en;
    logic    pc_inc;
    logic    pc_br;
    logic    pc_jal;
    logic    pc_jr;
    logic    ab_en;
    logic    alu_en;
    logic    rf_we;
    wb_sel_e wsel;
    logic    addr_alu;
    logic    mem_we;
    logic    rb_low;
    logic    imm_zext;
    logic    opb_imm;
    alu_op_e alu_op;
  } ctl_t;

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NREG)-1:0]  waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0]  raddr_a,
  output logic [DW-1:0]            rdata_a,
  input  logic [$clog2(NREG)-1:0]  raddr_b,
  output logic [DW-1:0]            rdata_b
);
  localparam int unsigned AW = $clog2(NREG);

  logic [DW-1:0] rows [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_row
    if (g == 0) begin : g_zero
      // row zero has no storage and reads as zero
      assign rows[g] = '0;
    end else begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (we && (waddr == AW'(g))) begin
          q <= wdata;
        end
      end
      assign rows[g] = q;
    end
  end

  assign rdata_a = rows[raddr_a];
  assign rdata_b = rows[raddr_b];

endmodule

// File: rtl/mc16_shift.sv
module mc16_shift #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [3:0]    kind,
  output logic [DW-1:0] y
);
  import mc16_pkg::*;

  always_comb begin
    case (kind)
      SHK_LSL: y = {a[DW-2:0], 1'b0};
      SHK_LSR: y = {1'b0, a[DW-1:1]};
      SHK_ASR: y = {a[DW-1], a[DW-1:1]};
      SHK_ROL: y = {a[DW-2:0], a[DW-1]};
      SHK_ROR: y = {a[0], a[DW-1:1]};
      default: y = a;
    endcase
  end

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu #(
  parameter int unsigned DW = 16
) (
  input  mc16_pkg::alu_op_e op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic [3:0]        shkind,
  output logic [DW-1:0]     y
);
  import mc16_pkg::*;

  logic [DW-1:0] sh_y;
  logic          lt;

  mc16_shift #(.DW(DW)) u_shift (
    .a    (a),
    .kind (shkind),
    .y    (sh_y)
  );

  assign lt = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      AL_ADD:  y = a + b;
      AL_SUB:  y = a - b;
      AL_AND:  y = a & b;
      AL_OR:   y = a | b;
      AL_SLT:  y = {{(DW-1){1'b0}}, lt};
      AL_SHF:  y = sh_y;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            opc,
  input  logic                  zero,
  output mc16_pkg::state_e      state,
  output mc16_pkg::ctl_t        ctl
);
  import mc16_pkg::*;

  state_e  st_q, st_d;
  opcode_e op;
  logic    is_rtype;
  logic    is_mem;

  assign op       = opcode_e'(opc);
  assign is_rtype = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
                    (op == OP_OR)  || (op == OP_SLT);
  assign is_mem   = (op == OP_LW) || (op == OP_SW);

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FETCH;
    end else begin
      st_q <= st_d;
    end
  end

  assign state = st_q;

  // next state and control decode
  always_comb begin
    ctl      = '0;
    ctl.wsel = WB_ALU;
    st_d     = st_q;

    // datapath operation select, fixed per opcode
    case (op)
      OP_ADD, OP_ADDI, OP_LW, OP_SW: ctl.alu_op = AL_ADD;
      OP_SUB, OP_BEQ, OP_BNE:        ctl.alu_op = AL_SUB;
      OP_AND, OP_ANDI:               ctl.alu_op = AL_AND;
      OP_OR, OP_ORI:                 ctl.alu_op = AL_OR;
      OP_SLT, OP_SLTI:               ctl.alu_op = AL_SLT;
      OP_SHIFT:                      ctl.alu_op = AL_SHF;
      default:                       ctl.alu_op = AL_ADD;
    endcase
    ctl.opb_imm  = (op == OP_ADDI) || (op == OP_ANDI) || (op == OP_ORI) ||
                   (op == OP_SLTI) || is_mem;
    ctl.imm_zext = (op == OP_ANDI) || (op == OP_ORI);
    ctl.rb_low   = is_rtype || (op == OP_JR);

    case (st_q)
      ST_FETCH: begin
        st_d = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.ir_en  = 1'b1;
        ctl.pc_inc = 1'b1;
        st_d       = ST_REGRD;
      end
      ST_REGRD: begin
        if (op == OP_JAL) begin
          ctl.pc_jal = 1'b1;
          ctl.rf_we  = 1'b1;
          ctl.wsel   = WB_LINK;
          st_d       = ST_FETCH;
        end else if (op == OP_JR) begin
          ctl.pc_jr = 1'b1;
          st_d      = ST_FETCH;
        end else begin
          ctl.ab_en = 1'b1;
          st_d      = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if ((op == OP_BEQ) || (op == OP_BNE)) begin
          ctl.pc_br = (op == OP_BEQ) ? zero : !zero;
          st_d      = ST_FETCH;
        end else begin
          ctl.alu_en = 1'b1;
          st_d       = is_mem ? ST_MEM : ST_WB;
        end
      end
      ST_MEM: begin
        ctl.addr_alu = 1'b1;
        ctl.mem_we   = (op == OP_SW);
        st_d         = (op == OP_LW) ? ST_WB : ST_FETCH;
      end
      ST_WB: begin
        ctl.rf_we = 1'b1;
        ctl.wsel  = (op == OP_LW) ? WB_MEM : WB_ALU;
        st_d      = ST_FETCH;
      end
      default: begin
        st_d = ST_FETCH;
      end
    endcase
  end

endmodule

// File: rtl/mc16_core.sv
module mc16_core #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);
  import mc16_pkg::*;

  localparam int unsigned NREG = 2 ** RIDX_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_n, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_i_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_i_n  <= rst_s1_n;
    end
  end

  state_e                st;
  ctl_t                  ctl;
  logic [INSTR_W-1:0]    ir_q;
  logic [DW-1:0]         pc_q, pc_d;
  logic                  pc_en;
  logic [DW-1:0]         a_q, b_q, alu_q;
  logic [DW-1:0]         rd_a, rd_b;
  logic [RIDX_W-1:0]     ra, rb, rf_waddr;
  logic [DW-1:0]         rf_wdata;
  logic [DW-1:0]         imm_sx, imm_zx, opb, alu_y;
  logic                  alu_zero;

  mc16_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_i_n),
    .opc   (ir_q[INSTR_W-1 -: OPC_W]),
    .zero  (alu_zero),
    .state (st),
    .ctl   (ctl)
  );

  // register operands
  assign ra = ir_q[7:4];
  assign rb = ctl.rb_low ? ir_q[3:0] : ir_q[11:8];

  assign rf_waddr = (ctl.wsel == WB_LINK) ? RIDX_W'(LINK_REG) : ir_q[11:8];
  always_comb begin
    case (ctl.wsel)
      WB_MEM:  rf_wdata = mem_rdata;
      WB_LINK: rf_wdata = pc_q;
      default: rf_wdata = alu_q;
    endcase
  end

  mc16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (ctl.rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (ra),
    .rdata_a (rd_a),
    .raddr_b (rb),
    .rdata_b (rd_b)
  );

  // constant field extension
  assign imm_sx = {{(DW-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_zx = {{(DW-IMM_W){1'b0}}, ir_q[IMM_W-1:0]};
  assign opb    = ctl.opb_imm ? (ctl.imm_zext ? imm_zx : imm_sx) : b_q;

  mc16_alu #(.DW(DW)) u_alu (
    .op     (ctl.alu_op),
    .a      (a_q),
    .b      (opb),
    .shkind (ir_q[3:0]),
    .y      (alu_y)
  );

  assign alu_zero = (alu_y == '0);

  // program counter next value
  assign pc_en = ctl.pc_inc | ctl.pc_br | ctl.pc_jal | ctl.pc_jr;
  always_comb begin
    if (ctl.pc_inc) begin
      pc_d = pc_q + DW'(1);
    end else if (ctl.pc_br) begin
      pc_d = pc_q + imm_sx;
    end else if (ctl.pc_jal) begin
      pc_d = {pc_q[DW-1:JADDR_W], ir_q[JADDR_W-1:0]};
    end else begin
      pc_d = rd_b;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.ir_en) begin
      ir_q <= mem_rdata[INSTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.ab_en) begin
      a_q <= rd_a;
      b_q <= rd_b;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.alu_en) begin
      alu_q <= alu_y;
    end
  end

  // memory port
  assign mem_addr  = ctl.addr_alu ? alu_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = ctl.mem_we;

endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk (
  input logic                 clk,
  input logic                 rst_n,
  input mc16_pkg::state_e     state,
  input logic [15:0]          ir,
  input logic [15:0]          pc,
  input logic [15:0]          mem_addr,
  input logic                 mem_we,
  input logic [3:0]           ra,
  input logic [15:0]          rd_a
);
  import mc16_pkg::*;

  // R11
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R11
  we_store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state == ST_MEM && ir[15:12] == OP_SW));

  // R12
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |-> (mem_addr == pc));

  // R10
  fetch_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (state == ST_DECODE));

  // R10
  wb_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB) |=> (state == ST_FETCH));

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra == 4'd0) |-> (rd_a == 16'd0));

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH || state == ST_MEM || state == ST_WB) |=> $stable(pc));

endmodule

bind mc16_core mc16_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .state    (st),
  .ir       (ir_q),
  .pc       (pc_q),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .ra       (ra),
  .rd_a     (rd_a)
);

// File: tb/tb_mc16_core.sv
`timescale 1ns/1ps
module tb_mc16_core;

  logic        clk;
  logic        rst_n;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  mc16_core dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // shared memory, one cycle read latency
  logic [15:0] mem [256];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  typedef struct {
    int    addr;
    int    data;
    int    gap;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk  = 0;
  int n_fail = 0;
  int wp     = 0;
  int sa     = 128;
  int cyc    = 0;
  int last_cyc = 0;

  function automatic logic [15:0] enc(int op, int a, int b, int c);
    return {op[3:0], a[3:0], b[3:0], c[3:0]};
  endfunction

  task automatic emit(logic [15:0] w);
    mem[wp] = w;
    wp++;
  endtask

  task automatic expect_store(int addr, int data, int gap, string tag);
    exp_t e;
    e.addr = addr; e.data = data; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  // store register r at the running pointer r14, then advance r14
  task automatic st(int r, int val, int gap, string tag);
    emit(enc(10, r, 14, 0));
    emit(enc(5, 14, 14, 1));
    expect_store(sa, val, gap, tag);
    sa++;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares every store against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (mem_we) begin
        if (q.size() == 0) begin
          check(1'b0, "R11 unexpected store", int'(mem_addr), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(int'(mem_addr) == e.addr, {e.tag, " addr"}, int'(mem_addr), e.addr);
          check(int'(mem_wdata) == e.data, {e.tag, " data"}, int'(mem_wdata), e.data);
          if (e.gap >= 0)
            check((cyc - last_cyc) == e.gap, {e.tag, " R10 gap"}, cyc - last_cyc, e.gap);
        end
        last_cyc = cyc;
      end
    end
  end

  initial begin
    int p;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

    // r14 = 128 (store pointer)
    emit(enc(5, 14, 0, 4));
    for (int i = 0; i < 5; i++) emit(enc(13, 14, 14, 0));
    emit(enc(5, 1, 0, 7));            // r1 = 7
    emit(enc(5, 2, 0, 13));           // r2 = -3
    emit(enc(0, 3, 1, 2));  st(3, 16'h0004, -1, "R2 R3 ADD");
    emit(enc(1, 3, 1, 2));  st(3, 16'h000A, 15, "R3 SUB");
    emit(enc(2, 3, 1, 2));  st(3, 16'h0005, 15, "R3 AND");
    emit(enc(3, 3, 1, 2));  st(3, 16'hFFFF, 15, "R3 OR");
    emit(enc(4, 3, 2, 1));  st(3, 16'h0001, 15, "R3 SLT signed true");
    emit(enc(4, 3, 1, 2));  st(3, 16'h0000, 15, "R3 SLT signed false");
    emit(enc(6, 3, 2, 15)); st(3, 16'h000D, 15, "R4 ANDI zero-extend");
    emit(enc(7, 3, 0, 8));  st(3, 16'h0008, 15, "R4 ORI zero-extend");
    emit(enc(5, 3, 1, 8));  st(3, 16'hFFFF, 15, "R4 ADDI sign-extend");
    emit(enc(8, 3, 1, 15)); st(3, 16'h0000, 15, "R4 SLTI false");
    emit(enc(8, 3, 2, 14)); st(3, 16'h0001, 15, "R4 SLTI true");
    emit(enc(13, 3, 2, 0)); st(3, 16'hFFFA, 15, "R7 LSL");
    emit(enc(13, 3, 2, 1)); st(3, 16'h7FFE, 15, "R7 LSR");
    emit(enc(13, 3, 2, 2)); st(3, 16'hFFFE, 15, "R7 ASR");
    emit(enc(13, 3, 2, 3)); st(3, 16'hFFFB, 15, "R7 ROL");
    emit(enc(13, 3, 1, 4)); st(3, 16'h8003, 15, "R7 ROR");
    emit(enc(13, 3, 1, 9)); st(3, 16'h0007, 15, "R7 undefined kind");
    // loads with negative offsets
    emit(enc(9, 4, 14, 14)); st(4, 16'h8003, 16, "R5 LW");
    emit(enc(9, 5, 14, 12));
    emit(enc(0, 5, 5, 1));  st(5, 16'h0002, 21, "R5 LW then ADD");
    // store with offset -8
    emit(enc(10, 1, 14, 8));
    expect_store(sa - 8, 16'h0007, 10, "R5 SW negative offset");
    // write to r0 is dropped
    emit(enc(5, 0, 0, 5));  st(0, 16'h0000, 10, "R9 r0 write ignored");
    // BEQ taken, skipping a stray store
    emit(enc(11, 1, 1, 1));
    emit(enc(10, 1, 0, 0));
    st(1, 16'h0007, 14, "R6 BEQ taken");
    // BNE not taken
    emit(enc(12, 1, 1, 1));
    emit(enc(5, 10, 0, 3));
    st(10, 16'h0003, 19, "R6 BNE not taken");
    // BEQ not taken
    emit(enc(11, 2, 1, 1));
    emit(enc(5, 10, 10, 1));
    st(10, 16'h0004, 19, "R6 BEQ not taken");
    // counted loop with a backward BNE
    emit(enc(5, 6, 0, 3));
    emit(enc(5, 7, 0, 0));
    emit(enc(5, 7, 7, 2));
    emit(enc(5, 6, 6, 15));
    emit(enc(12, 0, 6, 13));
    st(7, 16'h0006, 62, "R6 backward BNE loop");
    // JAL to a routine that stores the link, then JR back
    p = wp;
    emit({4'hE, 12'(p + 4)});
    emit(enc(10, 9, 14, 0));
    emit(enc(5, 14, 14, 1));
    emit(enc(11, 0, 0, 4));
    emit(enc(10, 15, 14, 0));
    emit(enc(5, 14, 14, 1));
    emit(enc(5, 9, 0, 5));
    emit(enc(15, 0, 0, 15));
    expect_store(sa, p + 1, 13, "R8 JAL link");
    sa++;
    expect_store(sa, 16'h0005, 18, "R8 JR return");
    sa++;
    emit(enc(5, 11, 0, 1));
    st(11, 16'h0001, 19, "R8 R12 after return");
    // park
    emit(enc(11, 0, 0, 15));

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_we == 1'b0, "R1 reset strobe", int'(mem_we), 0);
    check(mem_addr == 16'h0000, "R1 reset address", int'(mem_addr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_addr == 16'h0000, "R1 R12 first fetch address", int'(mem_addr), 0);

    begin
      int wd = 0;
      while (q.size() != 0 && wd < 20000) begin
        @(negedge clk);
        wd++;
      end
      check(q.size() == 0, "R12 watchdog all stores seen", q.size(), 0);
    end
    repeat (200) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule